// File: doc/BRIEF.md
# Joinable Lane FIFO Pair

This block holds the two word queues of one processing lane. The transmit queue carries words from the system to the lane engine. The receive queue carries words from the engine back to the system. Each queue has its own bank of `DEPTH` words. A mode input lets either queue take over the other queue's bank, which doubles its depth. The queue that gave up its bank then reports itself as full and empty at the same time, so neither side can use it.

Any change on a join input clears both queues in the same clock edge. Two kinds of misuse on the system side are recorded in sticky flags: writing to a full transmit queue, and reading from an empty receive queue. The misused queue itself is left untouched. Each flag is cleared by writing 1 to its clear bit. The data ports look ahead: each read-data output shows the head word of its queue while the queue holds data, and a read strobe removes that word at the clock edge.

Top module: `lane_fifo_pair`

## Requirements
- R1: After reset, both levels are 0, both empty outputs are 1, both full outputs are 0, and both error flags are 0.
- R2: In split mode each queue holds up to DEPTH words and returns them in write order. The level output counts the stored words, full is 1 at DEPTH and empty is 1 at 0. A read-data output shows the head word while its queue is not empty.
- R3: With join_tx_i=1 and join_rx_i=0, the transmit queue holds 2*DEPTH words. The receive queue then reports full=1, empty=1 and level 0, and it ignores engine writes.
- R4: With join_rx_i=1 and join_tx_i=0, the receive queue holds 2*DEPTH words. The transmit queue then reports full=1, empty=1 and level 0, so tx_not_full_o is 0.
- R5: With both join inputs at 1, the block behaves as in split mode: each queue holds DEPTH words.
- R6: In any cycle where a join input differs from its value in the previous cycle, both queues are emptied at the clock edge (levels read 0 afterwards). Writes and reads in that cycle are ignored.
- R7: A system write while tx_full_o=1 is dropped and the transmit level is unchanged. tx_over_o reads 1 from the next cycle on. This includes writes to a transmit queue that has given up its bank.
- R8: A system read while rx_empty_o=1 leaves the receive level unchanged. sys_rdata_o reads 0 in that cycle, and rx_under_o reads 1 from the next cycle on.
- R9: Both error flags are sticky. err_clr_i bit 0 clears tx_over_o and bit 1 clears rx_under_o. A new error in the same cycle as its clear leaves the flag at 1.
- R10: rx_not_empty_o is the inverse of rx_empty_o, and tx_not_full_o is the inverse of tx_full_o.
- R11: An engine read from an empty transmit queue, or an engine write to a full receive queue, is ignored and changes no level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| join_tx_i | input | 1 | Transmit queue takes both banks |
| join_rx_i | input | 1 | Receive queue takes both banks |
| sys_wr_i | input | 1 | System write strobe into the transmit queue |
| sys_wdata_i | input | DW | System write data |
| eng_rd_i | input | 1 | Engine read strobe from the transmit queue |
| eng_rdata_o | output | DW | Transmit head word (0 when empty) |
| eng_wr_i | input | 1 | Engine write strobe into the receive queue |
| eng_wdata_i | input | DW | Engine write data |
| sys_rd_i | input | 1 | System read strobe from the receive queue |
| sys_rdata_o | output | DW | Receive head word (0 when empty) |
| err_clr_i | input | 2 | Write-1 clears: bit 0 overflow flag, bit 1 underflow flag |
| tx_level_o | output | LW | Transmit word count |
| rx_level_o | output | LW | Receive word count |
| tx_full_o | output | 1 | Transmit queue full |
| tx_empty_o | output | 1 | Transmit queue empty |
| rx_full_o | output | 1 | Receive queue full |
| rx_empty_o | output | 1 | Receive queue empty |
| tx_not_full_o | output | 1 | Raw status: transmit queue has room |
| rx_not_empty_o | output | 1 | Raw status: receive queue has data |
| tx_over_o | output | 1 | Sticky system overflow flag |
| rx_under_o | output | 1 | Sticky system underflow flag |

## Verification
The assertions assume the join inputs change only between clock edges and stay stable while a stimulus cycle is in progress. They also assume that a strobe counts only in the cycle it is high. The level-bound check is skipped in the flush cycle, because the capacity may already have shrunk while the old count is still held. The bench drives every input on the falling edge, changes join inputs only through whole idle or stimulus cycles, and samples on the next falling edge.

// File: rtl/lane_fifo_pkg.sv
package lane_fifo_pkg;

  typedef enum logic [1:0] {
    MODE_SPLIT   = 2'd0,
    MODE_WIDE_TX = 2'd1,
    MODE_WIDE_RX = 2'd2
  } lane_mode_e;

  // both join bits set falls back to split
  function automatic lane_mode_e decode_mode(input logic jt, input logic jr);
    if (jt && !jr)      return MODE_WIDE_TX;
    else if (jr && !jt) return MODE_WIDE_RX;
    else                return MODE_SPLIT;
  endfunction

endpackage

// File: rtl/lane_fifo_ctl.sv
module lane_fifo_ctl #(
  parameter int DEPTH = 4,
  localparam int PW = $clog2(2 * DEPTH),
  localparam int LW = $clog2(2 * DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          wide_i,
  input  logic          off_i,
  input  logic          push_i,
  input  logic          pop_i,
  output logic          push_ok_o,
  output logic          pop_ok_o,
  output logic [PW-1:0] wptr_o,
  output logic [PW-1:0] rptr_o,
  output logic [LW-1:0] level_o,
  output logic          full_o,
  output logic          empty_o
);

  logic [LW-1:0] lvl_q, cap;
  logic [PW-1:0] wptr_q, rptr_q, last;

  assign cap  = wide_i ? LW'(2 * DEPTH) : LW'(DEPTH);
  assign last = wide_i ? PW'(2 * DEPTH - 1) : PW'(DEPTH - 1);

  assign full_o    = off_i | (lvl_q == cap);
  assign empty_o   = off_i | (lvl_q == '0);
  assign push_ok_o = push_i & ~full_o & ~flush_i;
  assign pop_ok_o  = pop_i & ~empty_o & ~flush_i;
  assign level_o   = off_i ? '0 : lvl_q;
  assign wptr_o    = wptr_q;
  assign rptr_o    = rptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= '0;
      wptr_q <= '0;
      rptr_q <= '0;
    end else if (flush_i) begin
      lvl_q  <= '0;
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      if (push_ok_o) wptr_q <= (wptr_q == last) ? '0 : wptr_q + 1'b1;
      if (pop_ok_o)  rptr_q <= (rptr_q == last) ? '0 : rptr_q + 1'b1;
      case ({push_ok_o, pop_ok_o})
        2'b10:   lvl_q <= lvl_q + 1'b1;
        2'b01:   lvl_q <= lvl_q - 1'b1;
        default: lvl_q <= lvl_q;
      endcase
    end
  end

  AST_LEVEL_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flush_i |-> lvl_q <= cap); // R2
  AST_FULL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && full_o && !pop_i && !flush_i |=> lvl_q == $past(lvl_q)); // R7
  AST_EMPTY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && empty_o && !push_i && !flush_i |=> lvl_q == $past(lvl_q)); // R8
  AST_FLUSH_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> lvl_q == '0); // R6

endmodule

// File: rtl/lane_fifo_err.sv
module lane_fifo_err #(
  parameter int NF = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NF-1:0] set_i,
  input  logic [NF-1:0] clr_i,
  output logic [NF-1:0] flag_o
);

  // a new event beats a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_o <= '0;
    else         flag_o <= (flag_o & ~clr_i) | set_i;
  end

  for (genvar i = 0; i < NF; i++) begin : g_chk
    AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flag_o[i] && !clr_i[i] |=> flag_o[i]); // R9
    AST_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> flag_o[i]); // R7
  end

endmodule

// File: rtl/lane_fifo_pair.sv
module lane_fifo_pair #(
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  localparam int PW = $clog2(2 * DEPTH),
  localparam int LW = $clog2(2 * DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          join_tx_i,
  input  logic          join_rx_i,
  input  logic          sys_wr_i,
  input  logic [DW-1:0] sys_wdata_i,
  input  logic          eng_rd_i,
  output logic [DW-1:0] eng_rdata_o,
  input  logic          eng_wr_i,
  input  logic [DW-1:0] eng_wdata_i,
  input  logic          sys_rd_i,
  output logic [DW-1:0] sys_rdata_o,
  input  logic [1:0]    err_clr_i,
  output logic [LW-1:0] tx_level_o,
  output logic [LW-1:0] rx_level_o,
  output logic          tx_full_o,
  output logic          tx_empty_o,
  output logic          rx_full_o,
  output logic          rx_empty_o,
  output logic          tx_not_full_o,
  output logic          rx_not_empty_o,
  output logic          tx_over_o,
  output logic          rx_under_o
);
  import lane_fifo_pkg::*;

  localparam int SLOTS = 2 * DEPTH;

  lane_mode_e    mode;
  logic [1:0]    join_q;
  logic          flush;
  logic          tx_push, tx_pop, rx_push, rx_pop;
  logic [PW-1:0] tx_wptr, tx_rptr, rx_wptr, rx_rptr;
  logic [DW-1:0] mem [SLOTS];
  logic [1:0]    err_set, err_flag;

  // receive queue starts in the upper bank and wraps into the lower one
  function automatic logic [PW-1:0] rx_slot(input logic [PW-1:0] p);
    int s;
    s = int'(p) + DEPTH;
    if (s >= SLOTS) s = s - SLOTS;
    return PW'(s);
  endfunction

  assign mode  = decode_mode(join_tx_i, join_rx_i);
  assign flush = (join_q != {join_tx_i, join_rx_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) join_q <= '0;
    else         join_q <= {join_tx_i, join_rx_i};
  end

  lane_fifo_ctl #(.DEPTH(DEPTH)) u_tx (
    .clk_i, .rst_ni,
    .flush_i  (flush),
    .wide_i   (mode == MODE_WIDE_TX),
    .off_i    (mode == MODE_WIDE_RX),
    .push_i   (sys_wr_i),
    .pop_i    (eng_rd_i),
    .push_ok_o(tx_push),
    .pop_ok_o (tx_pop),
    .wptr_o   (tx_wptr),
    .rptr_o   (tx_rptr),
    .level_o  (tx_level_o),
    .full_o   (tx_full_o),
    .empty_o  (tx_empty_o)
  );

  lane_fifo_ctl #(.DEPTH(DEPTH)) u_rx (
    .clk_i, .rst_ni,
    .flush_i  (flush),
    .wide_i   (mode == MODE_WIDE_RX),
    .off_i    (mode == MODE_WIDE_TX),
    .push_i   (eng_wr_i),
    .pop_i    (sys_rd_i),
    .push_ok_o(rx_push),
    .pop_ok_o (rx_pop),
    .wptr_o   (rx_wptr),
    .rptr_o   (rx_rptr),
    .level_o  (rx_level_o),
    .full_o   (rx_full_o),
    .empty_o  (rx_empty_o)
  );

  // the two queues never own the same slot, so both writes can land together
  always_ff @(posedge clk_i) begin
    if (tx_push) mem[tx_wptr]          <= sys_wdata_i;
    if (rx_push) mem[rx_slot(rx_wptr)] <= eng_wdata_i;
  end

  assign eng_rdata_o = tx_empty_o ? '0 : mem[tx_rptr];
  assign sys_rdata_o = rx_empty_o ? '0 : mem[rx_slot(rx_rptr)];

  assign tx_not_full_o  = ~tx_full_o;
  assign rx_not_empty_o = ~rx_empty_o;

  assign err_set = {sys_rd_i & rx_empty_o, sys_wr_i & tx_full_o};

  lane_fifo_err #(.NF(2)) u_err (
    .clk_i, .rst_ni,
    .set_i (err_set),
    .clr_i (err_clr_i),
    .flag_o(err_flag)
  );

  assign tx_over_o  = err_flag[0];
  assign rx_under_o = err_flag[1];

  AST_JOIN_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush |=> tx_level_o == '0 && rx_level_o == '0); // R6
  AST_NO_DOUBLE_OWNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_push && rx_push |-> tx_wptr != rx_slot(rx_wptr)); // R2

endmodule

// File: tb/tb_lane_fifo_pair.sv
module tb_lane_fifo_pair;
  localparam int DW = 32;
  localparam int DEPTH = 4;
  localparam int LW = $clog2(2 * DEPTH + 1);
  localparam int NV = 15;

  // {tx write, engine read, engine write, sys read, data, exp tx level, exp rx level}
  localparam logic [19:0] VEC [NV] = '{
    {4'b1000, 8'h11, 4'd1, 4'd0},
    {4'b1000, 8'h12, 4'd2, 4'd0},
    {4'b1010, 8'h13, 4'd3, 4'd1},
    {4'b1000, 8'h14, 4'd4, 4'd1},
    {4'b1000, 8'h15, 4'd4, 4'd1},
    {4'b0100, 8'h00, 4'd3, 4'd1},
    {4'b0010, 8'h21, 4'd3, 4'd2},
    {4'b0110, 8'h22, 4'd2, 4'd3},
    {4'b0010, 8'h23, 4'd2, 4'd4},
    {4'b0010, 8'h24, 4'd2, 4'd4},
    {4'b0001, 8'h00, 4'd2, 4'd3},
    {4'b1001, 8'h31, 4'd3, 4'd2},
    {4'b0101, 8'h00, 4'd2, 4'd1},
    {4'b0001, 8'h00, 4'd2, 4'd0},
    {4'b0001, 8'h00, 4'd2, 4'd0}
  };

  logic clk = 0, rst_ni = 0;
  logic join_tx = 0, join_rx = 0;
  logic sys_wr = 0, eng_rd = 0, eng_wr = 0, sys_rd = 0;
  logic [DW-1:0] sys_wdata = '0, eng_wdata = '0, eng_rdata, sys_rdata;
  logic [1:0] err_clr = '0;
  logic [LW-1:0] tx_level, rx_level;
  logic tx_full, tx_empty, rx_full, rx_empty, tx_not_full, rx_not_empty, tx_over, rx_under;
  int checks = 0, errors = 0;
  logic [DW-1:0] txq[$], rxq[$];

  always #2 clk = ~clk;

  lane_fifo_pair #(.DW(DW), .DEPTH(DEPTH)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .join_tx_i(join_tx), .join_rx_i(join_rx),
    .sys_wr_i(sys_wr), .sys_wdata_i(sys_wdata), .eng_rd_i(eng_rd), .eng_rdata_o(eng_rdata),
    .eng_wr_i(eng_wr), .eng_wdata_i(eng_wdata), .sys_rd_i(sys_rd), .sys_rdata_o(sys_rdata),
    .err_clr_i(err_clr), .tx_level_o(tx_level), .rx_level_o(rx_level),
    .tx_full_o(tx_full), .tx_empty_o(tx_empty), .rx_full_o(rx_full), .rx_empty_o(rx_empty),
    .tx_not_full_o(tx_not_full), .rx_not_empty_o(rx_not_empty),
    .tx_over_o(tx_over), .rx_under_o(rx_under)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic cyc(input logic tw, input logic er, input logic ew, input logic sr,
                     input logic [31:0] td, input logic [31:0] ed, input logic [1:0] clr);
    sys_wr = tw; eng_rd = er; eng_wr = ew; sys_rd = sr;
    sys_wdata = td; eng_wdata = ed; err_clr = clr;
    @(negedge clk);
    sys_wr = 0; eng_rd = 0; eng_wr = 0; sys_rd = 0; err_clr = '0;
  endtask

  initial begin
    repeat (20000) @(negedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    chk("R1 tx level", 32'(tx_level), 0);
    chk("R1 rx level", 32'(rx_level), 0);
    chk("R1 empties", {tx_empty, rx_empty}, 2'b11);
    chk("R1 fulls", {tx_full, rx_full}, 2'b00);
    chk("R1 flags", {tx_over, rx_under}, 2'b00);

    // table walk in split mode, heads checked against a queue model
    for (int i = 0; i < NV; i++) begin
      logic tw, er, ew, sr;
      logic [7:0] d;
      {tw, er, ew, sr} = VEC[i][19:16];
      d = VEC[i][15:8];
      if (txq.size() > 0) chk("R2 tx head", eng_rdata, txq[0]);
      if (rxq.size() > 0) chk("R2 rx head", sys_rdata, rxq[0]);
      else                chk("R8 empty read data", sys_rdata, 0);
      begin
        int ts, rs;
        ts = txq.size(); rs = rxq.size();
        if (er && ts > 0) void'(txq.pop_front());
        if (tw && ts < DEPTH) txq.push_back({24'h0, d});
        if (sr && rs > 0) void'(rxq.pop_front());
        if (ew && rs < DEPTH) rxq.push_back({24'h0, d + 8'h80});
      end
      cyc(tw, er, ew, sr, {24'h0, d}, {24'h0, d + 8'h80}, 2'b00);
      chk("R2 R7 R8 R11 tx level", 32'(tx_level), 32'(VEC[i][7:4]));
      chk("R2 R7 R8 R11 rx level", 32'(rx_level), 32'(VEC[i][3:0]));
      chk("R10 raw status", {rx_not_empty, tx_not_full}, {~rx_empty, ~tx_full});
    end
    chk("R7 overflow flag", tx_over, 1);
    chk("R8 underflow flag", rx_under, 1);

    cyc(0, 0, 0, 0, 0, 0, 2'b01);
    chk("R9 clear overflow only", {tx_over, rx_under}, 2'b01);
    cyc(0, 0, 0, 0, 0, 0, 2'b10);
    chk("R9 clear underflow", rx_under, 0);

    cyc(1, 0, 0, 0, 32'h41, 0, 2'b00);
    cyc(1, 0, 0, 0, 32'h42, 0, 2'b00);
    chk("R2 tx full at depth", {tx_full, tx_not_full}, 2'b10);
    cyc(1, 0, 0, 0, 32'h43, 0, 2'b01);
    chk("R9 set beats clear", tx_over, 1);
    chk("R7 level kept", 32'(tx_level), DEPTH);

    // R6: join change with a write in the same cycle
    join_tx = 1;
    cyc(1, 0, 0, 0, 32'h50, 0, 2'b00);
    chk("R6 tx flushed", 32'(tx_level), 0);
    chk("R6 rx flushed", 32'(rx_level), 0);
    chk("R3 donor rx status", {rx_full, rx_empty, rx_not_empty}, 3'b110);
    cyc(0, 0, 0, 0, 0, 0, 2'b01);
    for (int i = 0; i < 2 * DEPTH; i++) cyc(1, 0, 0, 0, 32'h60 + i, 0, 2'b00);
    chk("R3 wide tx level", 32'(tx_level), 2 * DEPTH);
    chk("R3 wide tx full", tx_full, 1);
    cyc(1, 0, 1, 0, 32'h70, 32'h71, 2'b00);
    chk("R7 wide overflow", tx_over, 1);
    chk("R3 donor ignores engine write", 32'(rx_level), 0);
    for (int i = 0; i < 2 * DEPTH; i++) begin
      chk("R3 wide tx order", eng_rdata, 32'h60 + i);
      cyc(0, 1, 0, 0, 0, 0, 2'b00);
    end
    chk("R3 wide tx drained", tx_empty, 1);

    // R5: both bits set is split
    join_rx = 1;
    cyc(0, 0, 0, 0, 0, 0, 2'b00);
    for (int i = 0; i < DEPTH + 1; i++) cyc(1, 0, 1, 0, 32'h80 + i, 32'h88 + i, 2'b00);
    chk("R5 tx depth", 32'(tx_level), DEPTH);
    chk("R5 rx depth", 32'(rx_level), DEPTH);

    // R4: join rx only
    join_tx = 0;
    cyc(0, 0, 0, 0, 0, 0, 2'b00);
    chk("R6 R4 flushed rx", 32'(rx_level), 0);
    chk("R4 donor tx status", {tx_full, tx_empty, tx_not_full}, 3'b110);
    for (int i = 0; i < 2 * DEPTH; i++) cyc(0, 0, 1, 0, 0, 32'h90 + i, 2'b00);
    chk("R4 wide rx level", 32'(rx_level), 2 * DEPTH);
    chk("R4 wide rx full", rx_full, 1);
    for (int i = 0; i < 2 * DEPTH; i++) begin
      chk("R4 wide rx order", sys_rdata, 32'h90 + i);
      cyc(0, 0, 0, 1, 0, 0, 2'b00);
    end
    chk("R4 wide rx drained", rx_empty, 1);

    // R11: engine read on empty tx in split mode
    join_rx = 0;
    cyc(0, 0, 0, 0, 0, 0, 2'b00);
    cyc(0, 1, 0, 0, 0, 0, 2'b00);
    chk("R11 empty pop ignored", {32'(tx_level), 31'h0, tx_empty}, {32'h0, 32'h1});
    cyc(1, 0, 0, 0, 32'hA5, 0, 2'b00);
    chk("R11 level after pop on empty", 32'(tx_level), 1);
    chk("R11 head after pop on empty", eng_rdata, 32'hA5);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule